// File: doc/BRIEF.md
# Interleaved Multi-Bank Block Fetcher

This block fills one cache block from a main memory made of several independent banks. A cache controller presents a word address, and the fetcher returns the whole block as a short burst of words. Each word comes with a valid strobe, and a done flag marks the last word. Every bank is a plain storage array. After a bank starts an access, it stays busy for a fixed cycle time, and its data is ready when that time ends.

In the default interleaved mapping, consecutive word addresses rotate across the banks. One address phase starts every bank of the block at once. The words then leave one after another on a single shared return bus, so a four-word fill costs 15 cycles. A parameter selects a contiguous mapping instead, which keeps a block inside one bank. The same four-word fill then costs 48 cycles, because every word needs its own address phase, bank cycle and return cycle. A single-word write port loads the arrays. It is honoured only while the fetcher is idle.

Top module: `blkf_top`

## Requirements
- R1: A fetch returns the stored words of the addressed block in ascending word-address order. With INTERLEAVE=1, word address w is held in bank w mod 4 at row w/4. With INTERLEAVE=0, it is held in bank w/64 at row w mod 64 (ADDR_W=8).
- R2: With BANK_CYC=10, the first word appears on rdata_o with rvalid_o high 12 clock edges after the edge that accepts the request.
- R3: With INTERLEAVE=1, the remaining words follow on the three immediately following cycles, so the fourth word arrives 15 edges after acceptance.
- R4: ready_o is high only when the fetcher is idle and every bank has finished its cycle time. It drops in the cycle after acceptance, stays low until the final word, and is high again in the cycle that carries done_o.
- R5: A request presented while ready_o is low is ignored. No extra words are returned for it.
- R6: The low two bits of addr_i are ignored. The block starting at the aligned address is always returned, beginning with its first word.
- R7: With INTERLEAVE=0, successive words of a block are 12 cycles apart, and the fourth arrives 48 edges after acceptance.
- R8: A write is stored only when wr_en_i is high while ready_o is high. A write presented at any other time leaves memory unchanged.
- R9: After reset, ready_o is high and rvalid_o and done_o are low.
- R10: Each accepted request produces exactly four rvalid_o pulses, and done_o is high only together with the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block fetch request |
| addr_i | input | ADDR_W | Word address of the block (low two bits ignored) |
| ready_o | output | 1 | Request and write acceptance |
| wr_en_i | input | 1 | Single-word write enable |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Returned word |
| rvalid_o | output | 1 | rdata_o holds a word of the block |
| done_o | output | 1 | Last word of the block |

## Verification
The latency and word-count properties assume that a new request is accepted only through the ready_o handshake. They therefore count from the accepting edge and never see a second acceptance inside a burst. The design enforces this through ready_o. The directed stimulus also deliberately raises req_i and wr_en_i in the middle of a burst, so the properties and the bench both observe that such inputs are dropped. All stimulus reads back blocks whose every word was written beforehand, so each expected word is known.

// File: rtl/blkf_pkg.sv
package blkf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/blkf_bank.sv
module blkf_bank #(
  parameter int DATA_W   = 32,
  parameter int ROW_W    = 6,
  parameter int BANK_CYC = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CYC_W = $clog2(BANK_CYC + 1);
  localparam logic [CYC_W-1:0] CYC_L = CYC_W'(BANK_CYC);
  localparam logic [CYC_W-1:0] ONE_L = CYC_W'(1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CYC_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_row_i] <= wr_data_i;
  end

  // cycle-time counter; data captured as the access completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      row_q   <= '0;
      rdata_q <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q <= CYC_L;
      row_q <= row_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_L;
      if (cnt_q == ONE_L) rdata_q <= mem_q[row_q];
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/blkf_seq.sv
module blkf_seq
  import blkf_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 8,
  parameter int INTERLEAVE = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic [ADDR_W-$clog2(NUM_BANKS)-1:0] blk_i,
  input  logic [NUM_BANKS-1:0]          busy_i,
  output logic                          ready_o,
  output logic [NUM_BANKS-1:0]          start_o,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] row_o,
  output logic                          ret_en_o,
  output logic [$clog2(NUM_BANKS)-1:0]  ret_sel_o,
  output logic                          ret_last_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam logic [BANK_W-1:0] LAST_W = BANK_W'(NUM_BANKS - 1);
  localparam logic [BANK_W-1:0] ONE_W  = BANK_W'(1);

  seq_state_e          state_q, state_d;
  logic [ROW_W-1:0]    blk_q, blk_d;
  logic [BANK_W-1:0]   word_q, word_d;
  logic [BANK_W-1:0]   cur_bank;
  logic [NUM_BANKS-1:0] start_vec;
  logic                all_idle;

  assign all_idle = (busy_i == '0);

  generate
    if (INTERLEAVE != 0) begin : g_il
      // whole block shares one row; word k sits in bank k
      assign cur_bank  = word_q;
      assign row_o     = blk_q;
      assign start_vec = '1;
    end else begin : g_contig
      logic [ADDR_W-1:0] waddr;
      assign waddr     = {blk_q, word_q};
      assign cur_bank  = waddr[ADDR_W-1:ROW_W];
      assign row_o     = waddr[ROW_W-1:0];
      assign start_vec = NUM_BANKS'(1) << cur_bank;
    end
  endgenerate

  assign ready_o = (state_q == ST_IDLE) && all_idle;

  always_comb begin
    state_d    = state_q;
    blk_d      = blk_q;
    word_d     = word_q;
    start_o    = '0;
    ret_en_o   = 1'b0;
    ret_sel_o  = cur_bank;
    ret_last_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && ready_o) begin
          blk_d   = blk_i;
          word_d  = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        start_o = start_vec;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (all_idle) begin
          ret_en_o = 1'b1;
          if (INTERLEAVE != 0) begin
            word_d  = word_q + ONE_W;
            state_d = ST_DRAIN;
          end else if (word_q == LAST_W) begin
            ret_last_o = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            word_d  = word_q + ONE_W;
            state_d = ST_SEND;
          end
        end
      end
      ST_DRAIN: begin
        ret_en_o = 1'b1;
        if (word_q == LAST_W) begin
          ret_last_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          word_d = word_q + ONE_W;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      word_q  <= word_d;
    end
  end
endmodule

// File: rtl/blkf_retbus.sv
module blkf_retbus #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata_i,
  input  logic                               ret_en_i,
  input  logic [$clog2(NUM_BANKS)-1:0]       ret_sel_i,
  input  logic                               ret_last_i,
  output logic [DATA_W-1:0]                  rdata_o,
  output logic                               rvalid_o,
  output logic                               done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      rvalid_o <= ret_en_i;
      done_o   <= ret_en_i && ret_last_i;
      if (ret_en_i) rdata_o <= bank_rdata_i[ret_sel_i];
    end
  end
endmodule

// File: rtl/blkf_top.sv
module blkf_top #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 4,
  parameter int BANK_CYC   = 10,
  parameter int INTERLEAVE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [NUM_BANKS-1:0]             busy, start;
  logic [ROW_W-1:0]                 row;
  logic                             ret_en, ret_last;
  logic [BANK_W-1:0]                ret_sel;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                             wr_ok;
  logic [BANK_W-1:0]                wr_bank;
  logic [ROW_W-1:0]                 wr_row;

  assign wr_ok = wr_en_i && ready_o;

  generate
    if (INTERLEAVE != 0) begin : g_wmap_il
      assign wr_bank = wr_addr_i[BANK_W-1:0];
      assign wr_row  = wr_addr_i[ADDR_W-1:BANK_W];
    end else begin : g_wmap_contig
      assign wr_bank = wr_addr_i[ADDR_W-1:ROW_W];
      assign wr_row  = wr_addr_i[ROW_W-1:0];
    end
  endgenerate

  blkf_seq #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .INTERLEAVE(INTERLEAVE)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .blk_i     (addr_i[ADDR_W-1:BANK_W]),
    .busy_i    (busy),
    .ready_o   (ready_o),
    .start_o   (start),
    .row_o     (row),
    .ret_en_o  (ret_en),
    .ret_sel_o (ret_sel),
    .ret_last_o(ret_last)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    blkf_bank #(
      .DATA_W  (DATA_W),
      .ROW_W   (ROW_W),
      .BANK_CYC(BANK_CYC)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start[g]),
      .row_i    (row),
      .wr_en_i  (wr_ok && (wr_bank == BANK_W'(g))),
      .wr_row_i (wr_row),
      .wr_data_i(wr_data_i),
      .busy_o   (busy[g]),
      .rdata_o  (bank_rdata[g])
    );
  end

  blkf_retbus #(
    .NUM_BANKS(NUM_BANKS),
    .DATA_W   (DATA_W)
  ) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bank_rdata_i(bank_rdata),
    .ret_en_i    (ret_en),
    .ret_sel_i   (ret_sel),
    .ret_last_i  (ret_last),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/blkf_chk.sv
module blkf_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_CYC   = 10,
  parameter int INTERLEAVE = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ready_o,
  input logic rvalid_o,
  input logic done_o
);
  localparam logic [15:0] FIRST_LAT = 16'(BANK_CYC + 2);
  localparam logic [15:0] IL_TOTAL  = 16'(BANK_CYC + 1 + NUM_BANKS);
  localparam logic [15:0] SQ_TOTAL  = 16'(NUM_BANKS * (BANK_CYC + 2));
  localparam logic [7:0]  LAST_CNT  = 8'(NUM_BANKS - 1);

  logic [15:0] lat_q;
  logic [7:0]  wcnt_q;
  logic        act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      wcnt_q <= '0;
      act_q  <= 1'b0;
    end else if (req_i && ready_o) begin
      lat_q  <= '0;
      wcnt_q <= '0;
      act_q  <= 1'b1;
    end else begin
      if (act_q)    lat_q  <= lat_q + 16'd1;
      if (rvalid_o) wcnt_q <= wcnt_q + 8'd1;
      if (done_o)   act_q  <= 1'b0;
    end
  end

  AST_FIRST_WORD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && wcnt_q == 8'd0) |-> (lat_q == FIRST_LAT)); // R2
  AST_IL_TOTAL_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (INTERLEAVE != 0 && done_o) |-> (lat_q == IL_TOTAL)); // R3
  AST_IL_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (INTERLEAVE != 0 && rvalid_o && !done_o) |=> rvalid_o); // R3
  AST_SEQ_TOTAL_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (INTERLEAVE == 0 && done_o) |-> (lat_q == SQ_TOTAL)); // R7
  AST_NOT_READY_MID_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !done_o) |-> !ready_o); // R4
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o); // R4
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rvalid_o && wcnt_q == LAST_CNT)); // R10
  AST_NO_EXTRA_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> act_q); // R5
endmodule

bind blkf_top blkf_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_CYC  (BANK_CYC),
  .INTERLEAVE(INTERLEAVE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ready_o (ready_o),
  .rvalid_o(rvalid_o),
  .done_o  (done_o)
);

// File: tb/blkf_top_tb_top.sv
`timescale 1ns/1ps
module blkf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ready_a, ready_b, rvalid_a, rvalid_b, done_a, done_b;
  logic [31:0] rdata_a, rdata_b;

  logic [31:0] shadow [256];
  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  blkf_top #(.INTERLEAVE(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .addr_i(addr), .ready_o(ready_a),
    .wr_en_i(wr_en_a), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rdata_o(rdata_a), .rvalid_o(rvalid_a), .done_o(done_a));

  blkf_top #(.INTERLEAVE(0)) dut_seq_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .addr_i(addr), .ready_o(ready_b),
    .wr_en_i(wr_en_b), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rdata_o(rdata_b), .rvalid_o(rvalid_b), .done_o(done_b));

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en_a = 1'b1; wr_en_b = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
    shadow[a] = d;
  endtask

  // one block fetch; inject raises a request and a write mid-burst
  task automatic fetch(input bit seq, input logic [7:0] a, input bit inject);
    logic [7:0] base;
    int n, got, stray, exp_n;
    logic rv, dn, rdy;
    logic [31:0] rd;
    base = {a[7:2], 2'b00};
    @(negedge clk);
    check_eq("R4 ready before request", seq ? ready_b : ready_a, 1);
    addr = a;
    if (seq) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    n = 0; got = 0;
    while (got < 4 && n < 200) begin
      rv  = seq ? rvalid_b : rvalid_a;
      dn  = seq ? done_b : done_a;
      rdy = seq ? ready_b : ready_a;
      rd  = seq ? rdata_b : rdata_a;
      if (n == 0) check_eq("R4 ready low after accept", rdy, 0);
      if (rv) begin
        exp_n = seq ? 12 + 12 * got : 12 + got;
        check_eq(got == 0 ? "R2 first word cycle" : (seq ? "R7 word cycle" : "R3 word cycle"), n, exp_n);
        check_eq("R1 R6 word data", rd, shadow[base + 8'(got)]);
        check_eq("R10 done flag", dn, got == 3);
        if (got == 3) check_eq("R4 ready with done", rdy, 1);
        else check_eq("R4 ready mid burst", rdy, 0);
        got++;
      end
      if (inject && n == 3) begin
        addr = a + 8'd16;
        wr_addr = base; wr_data = ~shadow[base];
        if (seq) begin req_b = 1'b1; wr_en_b = 1'b1; end
        else begin req_a = 1'b1; wr_en_a = 1'b1; end
      end
      if (n == 4) begin
        req_a = 1'b0; req_b = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    check_eq("R10 four words returned", got, 4);
    stray = 0;
    for (int i = 0; i < 60; i++) begin
      if (seq ? rvalid_b : rvalid_a) stray++;
      @(negedge clk);
    end
    check_eq("R5 no words for ignored request", stray, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R9 rvalid in reset", rvalid_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 ready after reset", ready_a, 1);
    check_eq("R9 ready after reset seq", ready_b, 1);
    check_eq("R9 rvalid after reset", rvalid_a | rvalid_b, 0);
    check_eq("R9 done after reset", done_a | done_b, 0);
  endtask

  task automatic t_load;
    for (int w = 0; w < 64; w++)
      do_write(8'(w), 32'hC0DE0000 ^ (32'(w) * 32'h00010203));
  endtask

  task automatic t_il_basic;
    fetch(1'b0, 8'd4, 1'b0);
    fetch(1'b0, 8'd20, 1'b0);
  endtask

  task automatic t_il_offset; // R6
    fetch(1'b0, 8'd39, 1'b0);
  endtask

  task automatic t_il_busy_ignore; // R5 R8
    fetch(1'b0, 8'd8, 1'b1);
    fetch(1'b0, 8'd8, 1'b0);
  endtask

  task automatic t_seq; // R7
    fetch(1'b1, 8'd12, 1'b0);
    fetch(1'b1, 8'd50, 1'b1);
    fetch(1'b1, 8'd48, 1'b0);
  endtask

  task automatic t_rewrite; // R8 accepted write is visible
    do_write(8'd21, 32'h12345678);
    fetch(1'b0, 8'd20, 1'b0);
    fetch(1'b1, 8'd20, 1'b0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load();
    t_il_basic();
    t_il_offset();
    t_il_busy_ignore();
    t_seq();
    t_rewrite();
    finish_run();
  end
endmodule